// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Sequencer

This block is the master-side sequencer of a two-wire serial bus controller. It works one byte transaction at a time. It talks to a bus engine through a small command channel: start with address and direction, send a byte and return its acknowledge, receive a byte, and stop. The engine produces the wire waveforms and is outside this block. The block holds a masked control word, a programmed byte count with a working copy that counts down, a 10-bit target address, and a packed holding buffer of up to four bytes. Software reaches that buffer through a 16-bit data port whose byte order can be swapped.

The host moves data through two valid/ready channels. On the write channel, a beat is taken when `wdat_valid` and `wdat_ready` are both high. `wdat_ready` is high only when the sequencer is idle and at least two buffer bytes are free. `wdat_valid` may be held, and the beat waits until ready rises. On the read channel, `rdat_data` is valid in the cycle where `rdat_valid` and `rdat_ready` are both high, and the beat is consumed at that edge. `rdat_ready` follows `host_idle`. Control, count and address writes are plain strobes and take effect only while `host_idle` is high. On the engine side, a command is taken when `cmd_valid` and `cmd_ready` are both high. The command fields stay stable until then. The engine answers every accepted command with a one-cycle `done` pulse.

Top module: `twi_byte_seq`

## Requirements
- R1: A control write stores only the bits in mask 0xCF87. Bit 15 is enable, bit 14 is swap, bit 10 is master, bit 9 is transmit, bit 8 is extended address, bit 2 is repeat, bit 1 is stop and bit 0 is start. The start bit clears once the start command completes, and the stop bit clears once the stop command completes.
- R2: A control write with enable and start set issues a start command (`cmd_op` 0) carrying the target address, with `cmd_rnw` equal to the inverse of the transmit bit. If the start is not acknowledged, `nack` is set, the master bit is cleared and no further command is issued.
- R3: Each start loads the working count from the programmed count. `cnt_q` shows the working count. Outside repeat mode, the working count drops by one for each byte sent or received.
- R4: In transmit mode, outside repeat, buffered bytes are sent (`cmd_op` 1) while the last acknowledge was positive, count remains and the buffer is not empty. When sending pauses, `xrdy` equals (acknowledged and count remaining). Any accepted data write clears `xrdy`.
- R5: Outside repeat, a working count of zero sets `ardy` and clears the master bit. If the stop bit is set, a stop command (`cmd_op` 3) follows and the working count is reloaded.
- R6: In receive mode, outside repeat, bytes are fetched (`cmd_op` 2) while count remains and fewer than four bytes are buffered. `rrdy` is set when fetching pauses with data held.
- R7: Without swap, a 16-bit write puts `wdat_data[7:0]` on the bus first and `[15:8]` second. With swap, the order is reversed. A write with `wdat_byte` high appends only `wdat_data[7:0]`.
- R8: A 16-bit read returns the oldest held byte in `[7:0]` without swap and in `[15:8]` with swap. A missing second byte reads as zero. The read removes up to two bytes, clears `rrdy` and lets fetching resume.
- R9: A read while the buffer is empty returns zero and sets the sticky `rd_err`. `flag_clr` bit 0 clears `ardy`, bit 1 clears `nack` and bit 2 clears `rd_err`.
- R10: In repeat mode the count is neither used nor changed. Each receive step fetches one byte and then waits. In transmit, all buffered bytes are sent. A set stop bit ends the transfer.
- R11: A sent byte that is not acknowledged sets `nack` and halts sending. A stop bit then set is honoured even though count remains.
- R12: `wdat_ready` is low while the sequencer is busy or more than two bytes are buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Control write value |
| cnt_wr | input | 1 | Programmed count write strobe |
| cnt_wdata | input | 16 | Programmed count value |
| sa_wr | input | 1 | Target address write strobe |
| sa_wdata | input | 10 | Target address value |
| wdat_valid | input | 1 | Host write beat valid |
| wdat_ready | output | 1 | Host write beat ready |
| wdat_data | input | 16 | Host write data |
| wdat_byte | input | 1 | Beat carries a single final byte |
| rdat_valid | input | 1 | Host read request |
| rdat_ready | output | 1 | Host read accepted |
| rdat_data | output | 16 | Host read data |
| flag_clr | input | 3 | Clear ardy, nack, rd_err |
| ctl_q | output | 16 | Current control word |
| cnt_q | output | 16 | Working count |
| host_idle | output | 1 | Sequencer idle |
| xrdy | output | 1 | Transmit ready |
| rrdy | output | 1 | Receive ready |
| ardy | output | 1 | Access ready |
| nack | output | 1 | No acknowledge seen |
| rd_err | output | 1 | Read of empty buffer |
| cmd_valid | output | 1 | Engine command valid |
| cmd_ready | input | 1 | Engine command ready |
| cmd_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| cmd_addr | output | 10 | Target address |
| cmd_rnw | output | 1 | Read direction for start |
| cmd_byte | output | 8 | Byte to send |
| done | input | 1 | Engine completion pulse |
| done_ack | input | 1 | Acknowledge of completed command |
| done_byte | input | 8 | Received byte |

## Verification
The assertions take three things for granted. The engine raises `done` for exactly one cycle after each accepted command and never while no command is outstanding. The host issues control, count and address writes only while `host_idle` is high. Control writes never coincide with data beats. The stimulus keeps to this in two ways. A bench engine model records each command on the falling edge and answers one cycle after acceptance. Every host action is preceded by a settle interval long enough for the sequencer to return to idle.

// File: rtl/twi_seq_pkg.sv
package twi_seq_pkg;
  typedef enum logic [1:0] {OP_START, OP_SEND, OP_RECV, OP_STOP} bus_op_e;
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_CMD, S_WAIT} seq_st_e;
  localparam int B_EN   = 15;
  localparam int B_SWAP = 14;
  localparam int B_MST  = 10;
  localparam int B_TRX  = 9;
  localparam int B_RM   = 2;
  localparam int B_STP  = 1;
  localparam int B_STT  = 0;
  localparam logic [15:0] CTL_KEEP = 16'hCF87;
endpackage

// File: rtl/twi_seq_buf.sv
module twi_seq_buf #(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          swap,
  input  logic                          push16,
  input  logic                          push8,
  input  logic [15:0]                   wdata,
  input  logic                          take,
  input  logic                          put,
  input  logic [7:0]                    put_byte,
  input  logic                          pop,
  output logic [$clog2(DEPTH+1)-1:0]    lvl,
  output logic [7:0]                    head_byte,
  output logic [15:0]                   rd_data
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int BW = DEPTH * 8;

  logic [BW-1:0] data, d_n;
  logic [LW-1:0] l_n;
  logic [7:0]    first_b, second_b, b0, b1;

  assign first_b  = swap ? wdata[15:8] : wdata[7:0];
  assign second_b = swap ? wdata[7:0]  : wdata[15:8];

  always_comb begin
    d_n = data;
    l_n = lvl;
    if (push16) begin
      d_n = {data[BW-17:0], first_b, second_b};
      l_n = lvl + LW'(2);
    end else if (push8) begin
      d_n = {data[BW-9:0], wdata[7:0]};
      l_n = lvl + LW'(1);
    end else if (take) begin
      l_n = lvl - LW'(1);
    end else if (put) begin
      for (int i = 0; i < DEPTH; i++)
        if (lvl == LW'(i)) d_n[8*i +: 8] = put_byte;
      l_n = lvl + LW'(1);
    end else if (pop) begin
      d_n = data >> 16;
      l_n = (lvl >= LW'(2)) ? lvl - LW'(2) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      lvl  <= '0;
    end else begin
      data <= d_n;
      lvl  <= l_n;
    end
  end

  always_comb begin
    head_byte = '0;
    for (int i = 0; i < DEPTH; i++)
      if (lvl == LW'(i + 1)) head_byte = data[8*i +: 8];
  end

  assign b0 = (lvl >= LW'(1)) ? data[7:0]  : 8'h00;
  assign b1 = (lvl >= LW'(2)) ? data[15:8] : 8'h00;
  assign rd_data = swap ? {b0, b1} : {b1, b0};

  // R12
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));
  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push16 |-> lvl <= LW'(DEPTH - 2));
endmodule

// File: rtl/twi_seq_fsm.sv
module twi_seq_fsm
  import twi_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_wr,
  input  logic [15:0]                ctl_wdata,
  input  logic                       cnt_wr,
  input  logic [CNT_W-1:0]           cnt_wdata,
  input  logic                       sa_wr,
  input  logic [ADDR_W-1:0]          sa_wdata,
  input  logic                       wr_fire,
  input  logic                       rd_fire,
  input  logic [$clog2(DEPTH+1)-1:0] lvl,
  input  logic [7:0]                 head_byte,
  output logic                       take,
  output logic                       put,
  input  logic [2:0]                 flag_clr,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [1:0]                 cmd_op,
  output logic [ADDR_W-1:0]          cmd_addr,
  output logic                       cmd_rnw,
  output logic [7:0]                 cmd_byte,
  input  logic                       done,
  input  logic                       done_ack,
  output logic [15:0]                ctl_q,
  output logic [CNT_W-1:0]           cnt_q,
  output logic                       idle,
  output logic                       swap,
  output logic                       xrdy,
  output logic                       rrdy,
  output logic                       ardy,
  output logic                       nack,
  output logic                       rd_err
);
  localparam int LW = $clog2(DEPTH + 1);

  seq_st_e           st;
  bus_op_e           op;
  logic [15:0]       ctl;
  logic [CNT_W-1:0]  cnt_prog, cnt_cur;
  logic [ADDR_W-1:0] saddr;
  logic [7:0]        byte_q;
  logic              active, last_ack;
  logic              has_cnt, has_data, has_room, rm;

  assign has_cnt  = cnt_cur != '0;
  assign has_data = lvl != '0;
  assign has_room = lvl < LW'(DEPTH);
  assign rm       = ctl[B_RM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  op <= OP_START;  ctl <= '0;
      cnt_prog <= '0;  cnt_cur <= '0;  saddr <= '0;  byte_q <= '0;
      active <= 1'b0;  last_ack <= 1'b0;
      xrdy <= 1'b0;  rrdy <= 1'b0;  ardy <= 1'b0;  nack <= 1'b0;  rd_err <= 1'b0;
    end else begin
      if (flag_clr[0]) ardy   <= 1'b0;
      if (flag_clr[1]) nack   <= 1'b0;
      if (flag_clr[2]) rd_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cnt_wr) cnt_prog <= cnt_wdata;
          if (sa_wr)  saddr    <= sa_wdata;
          if (ctl_wr) begin
            ctl <= ctl_wdata & CTL_KEEP;
            if (ctl_wdata[B_EN] && ctl_wdata[B_STT]) begin
              cnt_cur <= cnt_prog;
              op      <= OP_START;
              st      <= S_CMD;
            end else if (active) st <= S_EVAL;
          end else if (wr_fire) begin
            xrdy <= 1'b0;
            if (active) st <= S_EVAL;
          end else if (rd_fire) begin
            rrdy <= 1'b0;
            if (!has_data) rd_err <= 1'b1;
            else if (active) st <= S_EVAL;
          end
        end
        S_EVAL: begin
          st <= S_IDLE;
          if (rm) begin
            if (ctl[B_STP]) begin
              op <= OP_STOP;  st <= S_CMD;
            end else if (ctl[B_TRX]) begin
              if (has_data && last_ack) begin
                op <= OP_SEND;  byte_q <= head_byte;  st <= S_CMD;
              end else xrdy <= 1'b1;
            end else if (has_room) begin
              op <= OP_RECV;  st <= S_CMD;
            end else rrdy <= has_data;
          end else if (ctl[B_TRX]) begin
            if (last_ack && has_cnt && has_data) begin
              op <= OP_SEND;  byte_q <= head_byte;  st <= S_CMD;
            end else begin
              xrdy <= last_ack && has_cnt;
              if (!has_cnt) begin
                ardy <= 1'b1;  ctl[B_MST] <= 1'b0;
              end
              if (ctl[B_STP] && (!has_cnt || !last_ack)) begin
                op <= OP_STOP;  st <= S_CMD;
              end
            end
          end else begin
            if (has_cnt && has_room) begin
              op <= OP_RECV;  st <= S_CMD;
            end else begin
              rrdy <= has_data;
              if (!has_cnt) begin
                ardy <= 1'b1;  ctl[B_MST] <= 1'b0;
                if (ctl[B_STP]) begin
                  op <= OP_STOP;  st <= S_CMD;
                end
              end
            end
          end
        end
        S_CMD: if (cmd_ready) st <= S_WAIT;
        S_WAIT: if (done) begin
          case (op)
            OP_START: begin
              ctl[B_STT] <= 1'b0;
              if (done_ack) begin
                active <= 1'b1;  last_ack <= 1'b1;  st <= S_EVAL;
              end else begin
                nack <= 1'b1;  ctl[B_MST] <= 1'b0;  active <= 1'b0;  st <= S_IDLE;
              end
            end
            OP_SEND: begin
              last_ack <= done_ack;
              if (!done_ack) nack <= 1'b1;
              if (!rm) cnt_cur <= cnt_cur - CNT_W'(1);
              st <= S_EVAL;
            end
            OP_RECV: begin
              if (!rm) begin
                cnt_cur <= cnt_cur - CNT_W'(1);
                st <= S_EVAL;
              end else begin
                rrdy <= 1'b1;  st <= S_IDLE;
              end
            end
            default: begin
              active <= 1'b0;  ctl[B_STP] <= 1'b0;  cnt_cur <= cnt_prog;  st <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle      = st == S_IDLE;
  assign cmd_valid = st == S_CMD;
  assign cmd_op    = op;
  assign cmd_addr  = saddr;
  assign cmd_rnw   = ~ctl[B_TRX];
  assign cmd_byte  = byte_q;
  assign take      = (st == S_CMD) && cmd_ready && (op == OP_SEND);
  assign put       = (st == S_WAIT) && done && (op == OP_RECV);
  assign ctl_q     = ctl;
  assign cnt_q     = cnt_cur;
  assign swap      = ctl[B_SWAP];

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && done && op == OP_SEND && !rm) |=> cnt_cur == $past(cnt_cur) - CNT_W'(1));
  // R5
  ardy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ardy) |-> cnt_cur == '0);
  // R10
  rm_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && done && (op == OP_SEND || op == OP_RECV) && rm) |=> $stable(cnt_cur));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !flag_clr[2]) |=> rd_err);
endmodule

// File: rtl/twi_byte_seq.sv
module twi_byte_seq #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              sa_wr,
  input  logic [ADDR_W-1:0] sa_wdata,
  input  logic              wdat_valid,
  output logic              wdat_ready,
  input  logic [15:0]       wdat_data,
  input  logic              wdat_byte,
  input  logic              rdat_valid,
  output logic              rdat_ready,
  output logic [15:0]       rdat_data,
  input  logic [2:0]        flag_clr,
  output logic [15:0]       ctl_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              host_idle,
  output logic              xrdy,
  output logic              rrdy,
  output logic              ardy,
  output logic              nack,
  output logic              rd_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_rnw,
  output logic [7:0]        cmd_byte,
  input  logic              done,
  input  logic              done_ack,
  input  logic [7:0]        done_byte
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [LW-1:0] lvl;
  logic [7:0]    head_byte;
  logic          take, put, swap, wr_fire, rd_fire;

  assign wdat_ready = host_idle && (lvl <= LW'(DEPTH - 2));
  assign wr_fire    = wdat_valid && wdat_ready;
  assign rdat_ready = host_idle;
  assign rd_fire    = rdat_valid && host_idle;

  twi_seq_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .swap(swap),
    .push16(wr_fire && !wdat_byte), .push8(wr_fire && wdat_byte),
    .wdata(wdat_data), .take(take), .put(put), .put_byte(done_byte),
    .pop(rd_fire && (lvl != '0)), .lvl(lvl), .head_byte(head_byte),
    .rd_data(rdat_data)
  );

  twi_seq_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .sa_wr(sa_wr), .sa_wdata(sa_wdata),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .lvl(lvl), .head_byte(head_byte), .take(take), .put(put),
    .flag_clr(flag_clr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_rnw(cmd_rnw), .cmd_byte(cmd_byte),
    .done(done), .done_ack(done_ack),
    .ctl_q(ctl_q), .cnt_q(cnt_q), .idle(host_idle), .swap(swap),
    .xrdy(xrdy), .rrdy(rrdy), .ardy(ardy), .nack(nack), .rd_err(rd_err)
  );
endmodule

// File: tb/twi_byte_seq_tb.sv
module twi_byte_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, cnt_wr = 0, sa_wr = 0;
  logic [15:0] ctl_wdata = '0, cnt_wdata = '0;
  logic [9:0] sa_wdata = '0;
  logic wdat_valid = 0, wdat_byte = 0, rdat_valid = 0;
  logic [15:0] wdat_data = '0;
  logic [2:0] flag_clr = '0;
  logic wdat_ready, rdat_ready, host_idle, xrdy, rrdy, ardy, nack, rd_err;
  logic [15:0] rdat_data, ctl_q, cnt_q;
  logic cmd_valid, cmd_rnw;
  logic cmd_ready = 1'b1;
  logic [1:0] cmd_op;
  logic [9:0] cmd_addr;
  logic [7:0] cmd_byte;
  logic done = 0, done_ack = 0;
  logic [7:0] done_byte = '0;

  int vectors = 0, fails = 0;
  bit finished = 0;

  logic [1:0] log_op [64];
  logic [9:0] log_val [64];
  logic       log_rnw [64];
  int log_n = 0, send_idx = 0, nack_at = 99;
  logic ack_start = 1'b1;
  logic [7:0] rx_seed = 8'h00;
  bit pend = 0;
  logic r_ack;
  logic [7:0] r_byte;

  always #10 clk = ~clk;

  twi_byte_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .sa_wr(sa_wr), .sa_wdata(sa_wdata),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .wdat_byte(wdat_byte), .rdat_valid(rdat_valid), .rdat_ready(rdat_ready),
    .rdat_data(rdat_data), .flag_clr(flag_clr), .ctl_q(ctl_q), .cnt_q(cnt_q),
    .host_idle(host_idle), .xrdy(xrdy), .rrdy(rrdy), .ardy(ardy), .nack(nack),
    .rd_err(rd_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_rnw(cmd_rnw),
    .cmd_byte(cmd_byte), .done(done), .done_ack(done_ack), .done_byte(done_byte)
  );

  // Bus engine model: records on falling edge, answers one cycle after acceptance
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        done = 1'b1;  done_ack = r_ack;  done_byte = r_byte;  pend = 0;
      end else begin
        done = 1'b0;
        if (cmd_valid) begin
          pend = 1;
          r_byte = 8'h00;
          r_ack  = 1'b1;
          if (log_n < 64) begin
            log_op[log_n]  = cmd_op;
            log_rnw[log_n] = cmd_rnw;
            log_val[log_n] = (cmd_op == 2'd0) ? cmd_addr :
                             (cmd_op == 2'd1) ? {2'b00, cmd_byte} : 10'h000;
          end
          log_n++;
          case (cmd_op)
            2'd0: r_ack = ack_start;
            2'd1: begin r_ack = (send_idx != nack_at); send_idx++; end
            2'd2: begin r_byte = rx_seed; rx_seed = rx_seed + 8'd1; end
            default: r_ack = 1'b1;
          endcase
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic clr_log();
    log_n = 0;  send_idx = 0;  nack_at = 99;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
    settle();
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_wr = 1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 0;
  endtask

  task automatic wr_sa(input logic [9:0] v);
    @(negedge clk); sa_wr = 1; sa_wdata = v;
    @(negedge clk); sa_wr = 0;
  endtask

  task automatic wr_dat(input logic [15:0] v, input logic b8);
    @(negedge clk);
    while (!wdat_ready) @(negedge clk);
    wdat_valid = 1; wdat_data = v; wdat_byte = b8;
    @(negedge clk); wdat_valid = 0; wdat_byte = 0;
    settle();
  endtask

  task automatic rd_dat(input string tag, input logic [15:0] exp);
    @(negedge clk);
    rdat_valid = 1;
    #1 chk(tag, rdat_data, exp);
    @(negedge clk); rdat_valid = 0;
    settle();
  endtask

  task automatic clr_flags(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 reset ctl", ctl_q, 16'h0000);
    chk("R3 reset cnt", cnt_q, 16'h0000);
    chk("R5 reset flags", {xrdy, rrdy, ardy, nack, rd_err}, 5'b0);
    chk("R12 reset idle/ready", {host_idle, wdat_ready, cmd_valid}, 3'b110);
  endtask

  task automatic t_mask();
    clr_log();
    wr_ctl(16'h7FFE);
    chk("R1 mask", ctl_q, 16'h4F86);
    chk("R2 no start without enable", log_n, 0);
  endtask

  task automatic t_tx_normal();
    clr_log();
    wr_sa(10'h050); wr_cnt(16'd3);
    wr_ctl(16'h8601);
    chk("R2 start op", log_op[0], 2'd0);
    chk("R2 start addr", log_val[0], 10'h050);
    chk("R2 start rnw", log_rnw[0], 1'b0);
    chk("R1 stt self clear", ctl_q, 16'h8600);
    chk("R3 count loaded", cnt_q, 16'd3);
    chk("R4 xrdy after start", xrdy, 1'b1);
    wr_dat(16'hBBAA, 1'b0);
    chk("R7 first byte low", log_val[1], 10'h0AA);
    chk("R7 second byte high", log_val[2], 10'h0BB);
    chk("R3 count after two", cnt_q, 16'd1);
    chk("R4 xrdy count left", xrdy, 1'b1);
    wr_ctl(16'h8602);
    chk("R5 no stop with count", log_n, 3);
    wr_dat(16'h00CC, 1'b1);
    chk("R7 single byte", log_val[3], 10'h0CC);
    chk("R5 stop issued", log_op[4], 2'd3);
    chk("R5 ardy", ardy, 1'b1);
    chk("R1 mst and stp cleared", ctl_q, 16'h8200);
    chk("R3 count reloaded", cnt_q, 16'd3);
    chk("R4 xrdy cleared at zero", xrdy, 1'b0);
    clr_flags(3'b001);
    chk("R9 ardy clear", ardy, 1'b0);
  endtask

  task automatic t_tx_nack();
    clr_log();
    wr_sa(10'h021); wr_cnt(16'd4);
    wr_ctl(16'h8601);
    nack_at = 1;
    wr_dat(16'h2211, 1'b0);
    chk("R11 sent 11", log_val[1], 10'h011);
    chk("R11 sent 22", log_val[2], 10'h022);
    chk("R11 nack flag", nack, 1'b1);
    chk("R11 xrdy low", xrdy, 1'b0);
    chk("R11 halted", log_n, 3);
    chk("R3 count 2", cnt_q, 16'd2);
    wr_ctl(16'h8602);
    chk("R11 stop honoured", log_op[3], 2'd3);
    chk("R11 count reload", cnt_q, 16'd4);
    clr_flags(3'b010);
    chk("R9 nack clear", nack, 1'b0);
  endtask

  task automatic t_tx_swap();
    clr_log();
    wr_cnt(16'd2);
    wr_ctl(16'hC601);
    wr_dat(16'h1234, 1'b0);
    chk("R7 swap first", log_val[1], 10'h012);
    chk("R7 swap second", log_val[2], 10'h034);
    chk("R5 ardy at zero", ardy, 1'b1);
    chk("R5 mst cleared", ctl_q, 16'hC200);
    chk("R5 no stop yet", log_n, 3);
    wr_ctl(16'hC202);
    chk("R5 stop on stp", log_op[3], 2'd3);
    chk("R1 stp cleared", ctl_q, 16'hC200);
    clr_flags(3'b001);
  endtask

  task automatic t_start_nack();
    clr_log();
    ack_start = 1'b0;
    wr_ctl(16'h8601);
    chk("R2 nack on start", nack, 1'b1);
    chk("R2 master cleared", ctl_q, 16'h8200);
    chk("R2 nothing more", log_n, 1);
    ack_start = 1'b1;
    clr_flags(3'b010);
  endtask

  task automatic t_rx_normal();
    clr_log();
    rx_seed = 8'h10;
    wr_sa(10'h03A); wr_cnt(16'd5);
    wr_ctl(16'h8401);
    chk("R2 read direction", log_rnw[0], 1'b1);
    chk("R6 four fetched", log_n, 5);
    chk("R6 fetch op", log_op[4], 2'd2);
    chk("R3 count 1", cnt_q, 16'd1);
    chk("R6 rrdy", rrdy, 1'b1);
    chk("R12 ready low when full", wdat_ready, 1'b0);
    rd_dat("R8 read 1110", 16'h1110);
    chk("R8 fetch resumed", log_n, 6);
    chk("R5 ardy rx", ardy, 1'b1);
    chk("R12 ready low at three", wdat_ready, 1'b0);
    chk("R8 rrdy again", rrdy, 1'b1);
    rd_dat("R8 read 1312", 16'h1312);
    rd_dat("R8 read partial", 16'h0014);
    chk("R9 no err yet", rd_err, 1'b0);
    rd_dat("R9 empty read zero", 16'h0000);
    chk("R9 err set", rd_err, 1'b1);
    clr_flags(3'b100);
    chk("R9 err clear", rd_err, 1'b0);
    wr_ctl(16'h8002);
    chk("R5 rx stop", log_op[log_n-1], 2'd3);
    clr_flags(3'b001);
  endtask

  task automatic t_rx_repeat();
    clr_log();
    rx_seed = 8'h40;
    wr_cnt(16'd0);
    wr_ctl(16'hC405);
    chk("R10 one byte per step", log_n, 2);
    chk("R10 rrdy", rrdy, 1'b1);
    wr_ctl(16'hC404);
    chk("R10 second step", log_n, 3);
    chk("R10 count unchanged", cnt_q, 16'd0);
    rd_dat("R8 swap read", 16'h4041);
    chk("R10 step after read", log_n, 4);
    wr_ctl(16'hC406);
    chk("R10 stop", log_op[4], 2'd3);
    rd_dat("R8 swap partial", 16'h4200);
    chk("R10 no ardy", ardy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_tx_normal();
    t_tx_nack();
    t_tx_swap();
    t_start_nack();
    t_rx_normal();
    t_rx_repeat();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule